// File: doc/BRIEF.md
# ACPI Power-Management Event Register Block

This block holds the fixed-function power-management registers of a system controller: a 16-bit event status register, a 16-bit event enable register, a 16-bit control register and a free-running power-management timer. The timer is 24 bits wide by default. A host reaches them through a small synchronous I/O port. The port decodes accesses that fall inside a 64-byte window. Configuration inputs enable that window and set its base.

Four event sources are defined: timer overflow, global, power button and RTC alarm. The timer sets its overflow status each time its most significant bit changes. The power-button and RTC inputs set their status bits on a rising edge. Software clears a status bit by writing 1 to it. The SCI output stays high while any defined event is both pending and enabled.

A write to the control register with the suspend-enable bit set and a suspend type of zero produces a one-cycle soft-power-off request. The suspend-enable bit is not kept.

Top module: `acpi_pm_regs`

## Requirements
- R1: Inside the window, the register is chosen by io_addr[3:0]: 0x0 is status, 0x2 is enable, 0x4 is control (16-bit each, returned in io_rdata[15:0]) and 0x8 is the timer. Writing offset 0x2 stores io_wdata[15:0] into enable.
- R2: A read of offset 0x8 returns the timer count in the low TMR_W bits, and every bit above them reads 0.
- R3: A write to offset 0x0 clears each status bit whose io_wdata bit is 1 and leaves the other status bits unchanged.
- R4: The status bits sit at these positions: timer overflow at bit 0, global at bit 5, power button at bit 8 and RTC at bit 10. All other status bits read 0.
- R5: sci is high exactly when (status & enable & 0x0521) is non-zero.
- R6: Timer-overflow status (bit 0) sets on the tick that changes the timer's most significant bit, in either direction.
- R7: A write to offset 0x4 stores every bit of io_wdata[15:0] except bit 13, which always reads back 0.
- R8: A control write with io_wdata[13]=1 and io_wdata[11:10]=00 drives poweroff_req high for exactly the following cycle. Any other suspend type produces no request.
- R9: An access hits only when cfg_win_en is 1 and io_addr[15:6] equals cfg_base[15:6]. A missed write changes nothing, and a missed read returns 0.
- R10: The timer counts up by one on each cycle with tick=1 and wraps from all-ones to 0.
- R11: Writes to undefined offsets change nothing, and reads of them return 0. After reset, status, enable, control and the timer are all 0.
- R12: A rising edge on rtc_evt or pwrbtn_evt sets its status bit. When a set and a write-one-to-clear of the same bit happen in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_win_en | input | 1 | Register window enable |
| cfg_base | input | 32 | Window base; bits 15:6 are used |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid in the cycle of io_rd |
| tick | input | 1 | Timer increment enable |
| rtc_evt | input | 1 | RTC alarm event level |
| pwrbtn_evt | input | 1 | Power-button event level |
| sci | output | 1 | Level-sensitive system control interrupt |
| poweroff_req | output | 1 | One-cycle soft-off request |

## Verification
Two things can land on the same status bit in one cycle: a hardware set (a timer tick carrying the most significant bit over, or an input edge) and a software write-one-to-clear. The bench triggers this at random and also in directed cases. In those directed cases, an RTC edge, a power-button edge or the overflow tick is lined up with a clearing status write. A later read must show the bit still set, and sci must follow the enable mask in every cycle.

// File: rtl/acpi_pm_pkg.sv
package acpi_pm_pkg;
   localparam logic [3:0] OFS_STS = 4'h0;
   localparam logic [3:0] OFS_EN  = 4'h2;
   localparam logic [3:0] OFS_CTL = 4'h4;
   localparam logic [3:0] OFS_TMR = 4'h8;

   localparam int BIT_TMR = 0;
   localparam int BIT_GBL = 5;
   localparam int BIT_PWR = 8;
   localparam int BIT_RTC = 10;
   localparam int BIT_SUS = 13;

   localparam logic [15:0] EVT_MASK = 16'h0521;

   typedef struct packed {
      logic sts;
      logic en;
      logic ctl;
      logic tmr;
   } reg_sel_t;
endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
   parameter int TMR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [TMR_W-1:0] cnt,
   output logic             msb_flip
);
   localparam logic [TMR_W-1:0] CNT_MAX = '1;

   assign msb_flip = tick & (&cnt[TMR_W-2:0]);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

   a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == CNT_MAX) |=> (cnt == '0));
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));
endmodule

// File: rtl/pm_event_status.sv
module pm_event_status
   import acpi_pm_pkg::*;
#(
   parameter int N_EXT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmr_flip,
   input  logic [N_EXT-1:0] ext_evt,
   input  logic [15:0]      sts_clr,
   input  logic             en_we,
   input  logic [15:0]      en_wdata,
   output logic [15:0]      sts_q,
   output logic [15:0]      en_q,
   output logic             sci
);
   logic [N_EXT-1:0] ext_prev;
   logic [15:0]      set_vec [N_EXT+1];

   assign set_vec[0] = tmr_flip ? (16'h1 << BIT_TMR) : 16'h0;

   for (genvar g = 0; g < N_EXT; g++) begin : g_ext
      localparam int POS = (g == 0) ? BIT_RTC : BIT_PWR;
      always_ff @(posedge clk) begin
         if (!rst_n) ext_prev[g] <= 1'b0;
         else        ext_prev[g] <= ext_evt[g];
      end
      assign set_vec[g+1] = set_vec[g] |
         ((ext_evt[g] & ~ext_prev[g]) ? (16'h1 << POS) : 16'h0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q <= '0;
         en_q  <= '0;
      end else begin
         sts_q <= ((sts_q & ~sts_clr) | set_vec[N_EXT]) & EVT_MASK;
         if (en_we) en_q <= en_wdata;
      end
   end

   assign sci = |(sts_q & en_q & EVT_MASK);

   a_r6_tov_set: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_flip |=> sts_q[BIT_TMR]);
   a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr[BIT_TMR] && !tmr_flip) |=> !sts_q[BIT_TMR]);
   a_r12_rtc_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_evt[0] && !ext_prev[0]) |=> sts_q[BIT_RTC]);
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
   import acpi_pm_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctl_we,
   input  logic [15:0] ctl_wdata,
   output logic [15:0] ctl_q,
   output logic        poff_req
);
   logic soft_off;

   assign soft_off = ctl_we & ctl_wdata[BIT_SUS] & (ctl_wdata[11:10] == 2'b00);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q    <= '0;
         poff_req <= 1'b0;
      end else begin
         if (ctl_we) ctl_q <= ctl_wdata & ~(16'h1 << BIT_SUS);
         poff_req <= soft_off;
      end
   end

   a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      poff_req |=> !poff_req);
   a_r8_cause: assert property (@(posedge clk) disable iff (!rst_n)
      poff_req |-> $past(ctl_we && ctl_wdata[BIT_SUS] && ctl_wdata[11:10] == 2'b00));
endmodule

// File: rtl/acpi_pm_regs.sv
module acpi_pm_regs
   import acpi_pm_pkg::*;
#(
   parameter int          TMR_W   = 24,
   parameter int          DATA_W  = 32,
   parameter int          ADDR_W  = 16,
   parameter int          WIN_LG2 = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_win_en,
   input  logic [31:0]       cfg_base,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   input  logic              tick,
   input  logic              rtc_evt,
   input  logic              pwrbtn_evt,
   output logic              sci,
   output logic              poweroff_req
);
   localparam int TAG_W = ADDR_W - WIN_LG2;

   if (TMR_W < 2 || TMR_W > DATA_W) begin : g_bad_tmr
      $error("TMR_W must lie in 2..DATA_W");
   end
   if (DATA_W < 16 || WIN_LG2 < 4 || WIN_LG2 >= ADDR_W) begin : g_bad_bus
      $error("bus or window parameters out of range");
   end

   logic             win_hit;
   logic [3:0]       ofs;
   reg_sel_t         sel;
   logic [TMR_W-1:0] tmr_cnt;
   logic             tmr_flip;
   logic [15:0]      sts_q, en_q, ctl_q;
   logic [15:0]      sts_clr;

   assign win_hit = cfg_win_en &
      (io_addr[ADDR_W-1:WIN_LG2] == cfg_base[ADDR_W-1:WIN_LG2]);
   assign ofs = io_addr[3:0];

   always_comb begin
      sel     = '0;
      sel.sts = win_hit && (ofs == OFS_STS);
      sel.en  = win_hit && (ofs == OFS_EN);
      sel.ctl = win_hit && (ofs == OFS_CTL);
      sel.tmr = win_hit && (ofs == OFS_TMR);
   end

   assign sts_clr = (io_wr && sel.sts) ? io_wdata[15:0] : 16'h0;

   pm_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cnt(tmr_cnt), .msb_flip(tmr_flip)
   );

   pm_event_status #(.N_EXT(2)) u_evt (
      .clk(clk), .rst_n(rst_n), .tmr_flip(tmr_flip),
      .ext_evt({pwrbtn_evt, rtc_evt}), .sts_clr(sts_clr),
      .en_we(io_wr && sel.en), .en_wdata(io_wdata[15:0]),
      .sts_q(sts_q), .en_q(en_q), .sci(sci)
   );

   pm_ctrl u_ctl (
      .clk(clk), .rst_n(rst_n), .ctl_we(io_wr && sel.ctl),
      .ctl_wdata(io_wdata[15:0]), .ctl_q(ctl_q), .poff_req(poweroff_req)
   );

   always_comb begin
      io_rdata = '0;
      if (io_rd) begin
         if (sel.sts)      io_rdata[15:0]      = sts_q;
         else if (sel.en)  io_rdata[15:0]      = en_q;
         else if (sel.ctl) io_rdata[15:0]      = ctl_q;
         else if (sel.tmr) io_rdata[TMR_W-1:0] = tmr_cnt;
      end
   end

   a_r9_miss_write: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !win_hit) |=> ($stable(en_q) && $stable(ctl_q)));
   a_r7_sus_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && sel.ctl) |=> !ctl_q[BIT_SUS]);
   a_r2_timer_top: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && sel.tmr) |-> (io_rdata >> TMR_W) == '0);
endmodule

// File: tb/acpi_pm_regs_test.sv
module acpi_pm_regs_test;
   localparam int TW = 10;
   localparam logic [15:0] MASK = 16'h0521;
   localparam logic [31:0] BASE = 32'h0000_B01A;
   localparam logic [15:0] WB   = 16'hB000;

   logic        clk = 0, rst_n = 0;
   logic        cfg_win_en = 1;
   logic [31:0] cfg_base = BASE;
   logic [15:0] io_addr = 0;
   logic        io_wr = 0, io_rd = 0;
   logic [31:0] io_wdata = 0;
   logic [31:0] io_rdata;
   logic        tick = 0, rtc_evt = 0, pwrbtn_evt = 0;
   logic        sci, poweroff_req;

   int n_chk = 0, n_fail = 0;
   logic [TW-1:0] m_cnt;
   logic [15:0]   m_sts, m_en, m_ctl;
   logic          m_poff, m_rtc_p, m_pb_p;

   acpi_pm_regs #(.TMR_W(TW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_win_en(cfg_win_en), .cfg_base(cfg_base),
      .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .tick(tick), .rtc_evt(rtc_evt),
      .pwrbtn_evt(pwrbtn_evt), .sci(sci), .poweroff_req(poweroff_req)
   );

   always #5 clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic hit_of(input logic [15:0] a);
      return cfg_win_en && (a[15:6] == cfg_base[15:6]);
   endfunction

   function automatic logic [31:0] exp_read(input logic [15:0] a);
      if (!hit_of(a)) return 0;
      case (a[3:0])
         4'h0: return {16'h0, m_sts};
         4'h2: return {16'h0, m_en};
         4'h4: return {16'h0, m_ctl};
         4'h8: return {{(32-TW){1'b0}}, m_cnt};
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(input logic [15:0] a);
      if (!hit_of(a)) return "R9";
      case (a[3:0])
         4'h0: return "R3";
         4'h2: return "R1";
         4'h4: return "R7";
         4'h8: return "R2";
         default: return "R11";
      endcase
   endfunction

   task automatic model_reset();
      m_cnt = 0; m_sts = 0; m_en = 0; m_ctl = 0;
      m_poff = 0; m_rtc_p = 0; m_pb_p = 0;
   endtask

   task automatic step(input logic tk, rtc, pb, wr, rd,
                       input logic [15:0] a, input logic [31:0] d,
                       input string tag = "");
      logic tov;
      logic [15:0] setv, clr;
      @(negedge clk);
      tick = tk; rtc_evt = rtc; pwrbtn_evt = pb;
      io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d;
      #1;
      check("R5 sci", {31'h0, sci}, {31'h0, |(m_sts & m_en & MASK)});
      check("R8 poweroff", {31'h0, poweroff_req}, {31'h0, m_poff});
      if (rd) check(tag != "" ? tag : tag_of(a), io_rdata, exp_read(a));
      tov  = tk && (&m_cnt[TW-2:0]);
      setv = 0;
      if (tov) setv[0] = 1;
      if (rtc && !m_rtc_p) setv[10] = 1;
      if (pb && !m_pb_p) setv[8] = 1;
      clr = (wr && hit_of(a) && a[3:0] == 4'h0) ? d[15:0] : 16'h0;
      m_sts = ((m_sts & ~clr) | setv) & MASK;
      m_poff = 0;
      if (wr && hit_of(a) && a[3:0] == 4'h2) m_en = d[15:0];
      if (wr && hit_of(a) && a[3:0] == 4'h4) begin
         m_ctl  = d[15:0] & 16'hDFFF;
         m_poff = d[13] && d[11:10] == 2'b00;
      end
      if (tk) m_cnt = m_cnt + 1'b1;
      m_rtc_p = rtc; m_pb_p = pb;
   endtask

   task automatic rd_reg(input logic [3:0] o, input string tag);
      step(0, rtc_evt, pwrbtn_evt, 0, 1, WB | {12'h0, o}, 0, tag);
   endtask

   initial begin
      #1_500_000;
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      // R11: reset state
      rd_reg(4'h0, "R11 sts reset"); rd_reg(4'h2, "R11 en reset");
      rd_reg(4'h4, "R11 ctl reset"); rd_reg(4'h8, "R11 tmr reset");
      // R4: power-button edge lands on bit 8, RTC on bit 10
      step(0, 0, 1, 0, 0, 0, 0);
      rd_reg(4'h0, "R4 pwrbtn bit8");
      step(0, 1, 1, 0, 0, 0, 0);
      rd_reg(4'h0, "R4 rtc bit10");
      step(0, 1, 1, 1, 0, WB, 32'hFFFF);
      // R12: new RTC edge together with clearing write -> set wins
      step(0, 0, 0, 0, 0, 0, 0);
      step(0, 1, 0, 1, 0, WB, 32'h0400);
      rd_reg(4'h0, "R12 set wins");
      step(0, 1, 0, 1, 0, WB | 16'h2, 32'h0000_0521);
      // R10/R6: run timer to MSB flip while clearing bit 0 that cycle
      while (m_cnt != {1'b0, {(TW-1){1'b1}}}) step(1, 1, 0, 0, 0, 0, 0);
      step(1, 1, 0, 1, 0, WB, 32'h0001);
      rd_reg(4'h0, "R6 overflow sets");
      rd_reg(4'h8, "R10 count");
      while (m_cnt != '1) step(1, 1, 0, 0, 0, 0, 0);
      step(1, 1, 0, 1, 0, WB, 32'h0001);
      rd_reg(4'h8, "R10 wrap to 0");
      rd_reg(4'h0, "R6 overflow on fall");
      // R8/R7: suspend types
      step(0, 0, 0, 1, 0, WB | 16'h4, 32'h2400);
      rd_reg(4'h4, "R7 bit13 reads 0");
      step(0, 0, 0, 1, 0, WB | 16'h4, 32'hD3FF);
      rd_reg(4'h4, "R7 stored");
      // R9: window disabled / outside
      cfg_win_en = 0;
      step(0, 0, 0, 1, 0, WB | 16'h2, 32'h0);
      step(0, 0, 0, 0, 1, WB | 16'h2, 0, "R9 disabled read");
      cfg_win_en = 1;
      step(0, 0, 0, 1, 0, 16'hB040 | 16'h2, 32'h0);
      rd_reg(4'h2, "R9 miss write ignored");
      step(0, 0, 0, 1, 0, WB | 16'h6, 32'hFFFF);
      step(0, 0, 0, 0, 1, WB | 16'h6, 0, "R11 undefined read");
      // random mix
      for (int i = 0; i < 20000; i++) begin
         logic [15:0] a;
         logic [3:0]  o;
         int          k;
         k = $urandom_range(0, 9);
         o = (k < 3) ? 4'h0 : (k < 5) ? 4'h2 : (k < 7) ? 4'h4 : (k < 9) ? 4'h8 : 4'($urandom);
         a = WB | {10'h0, 2'($urandom), o};
         if ($urandom_range(0, 15) == 0) a = 16'($urandom);
         step($urandom_range(0, 1), $urandom_range(0, 7) == 0,
              $urandom_range(0, 7) == 0, $urandom_range(0, 3) == 0,
              $urandom_range(0, 1), a,
              (o == 4'h4 && $urandom_range(0, 3) != 0) ? 32'($urandom) & 32'hFFFF_D3FF : 32'($urandom));
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule